// File: doc/BRIEF.md
# Multi-channel ADC conversion sequencer

This block runs a complete sweep of converter inputs after a single convert-start pulse. It drives an external sample-and-hold and SAR converter through alternating conversion and acquisition phases, each timed in clock cycles. It sums the converter results for each input and writes one averaged value per input into an internal result register file. A read port gives access to that file.

A configuration word is captured when the sweep is accepted. It holds three 2-bit fields: how many inputs are swept, how many samples are averaged per input, and which of four acquisition windows is used. The first acquisition is assumed to have happened before the start pulse, so the sweep opens with a conversion. After that, every conversion except the first is preceded by an acquisition window. The sweep ends when the final conversion completes. Its length in cycles is reported so that it can be compared with the total-time rule.

Inputs are numbered 0 to CELLS-1 for cell voltages and CELLS to CELLS+AUXN-1 for auxiliary inputs. Cells are converted from the highest number downward, and the auxiliary inputs follow in ascending order.

Top module: `adc_sweep_seq`

## Requirements
- R1: After reset, busy, done, both strobes and sweep_cycles are 0, and every result register reads 0.
- R2: cfg_chan selects the number of inputs swept. Code 00 sweeps all CELLS+AUXN inputs, code 01 sweeps CELLS+AUXN/2, and codes 10 and 11 sweep only the CELLS cell inputs. The sweep performs (inputs × samples per input) conversions. Result registers for inputs that are not swept keep their previous value.
- R3: Conversion order is cell inputs CELLS-1 down to 0, then auxiliary inputs CELLS upward. chan_sel shows the input being converted while conv_strobe is high.
- R4: cfg_avg code k selects 2^k consecutive samples per input. The stored result is the sum of those samples shifted right by k.
- R5: cfg_acq code 0 to 3 selects ACQ_C0 to ACQ_C3 cycles of acquisition. Each acq_strobe is followed exactly that many cycles later by the next conv_strobe.
- R6: A sweep keeps busy high for exactly N×CONV_CYC + (N−1)×A cycles, where N is the number of conversions and A is the acquisition length. sweep_cycles holds that count once the sweep ends.
- R7: done is a one-cycle pulse. It is high in the cycle after the last result is written, and busy is already low in that cycle.
- R8: A start pulse while busy is ignored. Changes on the cfg inputs during a sweep have no effect, because the configuration is captured when the sweep starts.
- R9: conv_strobe marks the first cycle of each conversion, and the first one appears in the first busy cycle. acq_strobe marks the first cycle of each acquisition. Neither strobe is high while idle.
- R10: rd_data returns the result register selected by rd_addr. adc_data is sampled in the last cycle of each conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Convert-start pulse |
| cfg_chan | input | 2 | Input-count code |
| cfg_avg | input | 2 | Averaging code |
| cfg_acq | input | 2 | Acquisition window code |
| adc_data | input | SW | Converter result |
| conv_strobe | output | 1 | First cycle of a conversion |
| acq_strobe | output | 1 | First cycle of an acquisition |
| chan_sel | output | AW | Input currently addressed |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | End-of-sweep pulse |
| sweep_cycles | output | CW | Length of the last sweep in cycles |
| rd_addr | input | AW | Result register select |
| rd_data | output | SW | Selected result |

## Verification
The bench builds the block with a 3-cycle conversion and acquisition windows of 2, 3, 5 and 7 cycles, with the default 6 cell and 6 auxiliary inputs. With these short phases, all 64 combinations of input count, averaging and acquisition code fit in one run. Every sweep is therefore timed against the total-cycle rule, checked for input order, and checked for its averaged results. Each sweep also receives a start pulse and altered cfg inputs part way through, so every configuration exercises the ignored restart.

// File: rtl/adc_sweep_seq.sv
module adc_sweep_seq #(
  parameter int SW       = 12,
  parameter int CELLS    = 6,
  parameter int AUXN     = 6,
  parameter int CONV_CYC = 35,
  parameter int ACQ_C0   = 23,
  parameter int ACQ_C1   = 51,
  parameter int ACQ_C2   = 73,
  parameter int ACQ_C3   = 95,
  parameter int CW       = 16,
  localparam int NCH     = CELLS + AUXN,
  localparam int AW      = $clog2(NCH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    cfg_chan,
  input  logic [1:0]    cfg_avg,
  input  logic [1:0]    cfg_acq,
  input  logic [SW-1:0] adc_data,
  output logic          conv_strobe,
  output logic          acq_strobe,
  output logic [AW-1:0] chan_sel,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] sweep_cycles,
  input  logic [AW-1:0] rd_addr,
  output logic [SW-1:0] rd_data
);
  localparam int MAXLOG = 3;
  localparam int ACW    = SW + MAXLOG;
  localparam int TMAX   = (ACQ_C3 > CONV_CYC) ? ACQ_C3 : CONV_CYC;
  localparam int TW     = $clog2(TMAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_ACQ} st_t;

  st_t            st;
  logic [1:0]     avg_q, acq_q;
  logic [AW-1:0]  n_in_q, idx;
  logic [2:0]     rep;
  logic [TW-1:0]  tmr, acq_len;
  logic [ACW-1:0] acc, acc_nxt;
  logic [SW-1:0]  rf [NCH];
  logic [AW-1:0]  n_in_sel;
  logic           last_rep, last_in, phase_end;

  always_comb begin
    case (acq_q)
      2'd0:    acq_len = TW'(ACQ_C0);
      2'd1:    acq_len = TW'(ACQ_C1);
      2'd2:    acq_len = TW'(ACQ_C2);
      default: acq_len = TW'(ACQ_C3);
    endcase
    case (cfg_chan)
      2'b00:   n_in_sel = AW'(NCH);
      2'b01:   n_in_sel = AW'(CELLS + AUXN / 2);
      default: n_in_sel = AW'(CELLS);
    endcase
  end

  assign busy        = (st != S_IDLE);
  assign chan_sel    = (idx < AW'(CELLS)) ? AW'(CELLS - 1) - idx : idx;
  assign acc_nxt     = acc + ACW'(adc_data);
  assign last_rep    = (rep == 3'((1 << avg_q) - 1));
  assign last_in     = (idx == n_in_q - AW'(1));
  assign phase_end   = (tmr == '0);
  assign conv_strobe = (st == S_CONV) && (tmr == TW'(CONV_CYC - 1));
  assign acq_strobe  = (st == S_ACQ) && (tmr == acq_len - TW'(1));
  assign rd_data     = rf[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      avg_q        <= '0;
      acq_q        <= '0;
      n_in_q       <= '0;
      idx          <= '0;
      rep          <= '0;
      tmr          <= '0;
      acc          <= '0;
      done         <= 1'b0;
      sweep_cycles <= '0;
      for (int i = 0; i < NCH; i++) rf[i] <= '0;
    end else begin
      done <= 1'b0;
      if (busy) sweep_cycles <= sweep_cycles + CW'(1);
      case (st)
        S_IDLE: if (start) begin
          st           <= S_CONV;
          tmr          <= TW'(CONV_CYC - 1);
          avg_q        <= cfg_avg;
          acq_q        <= cfg_acq;
          n_in_q       <= n_in_sel;
          idx          <= '0;
          rep          <= '0;
          acc          <= '0;
          sweep_cycles <= '0;
        end
        S_CONV: if (phase_end) begin
          if (last_rep) begin
            rf[chan_sel] <= SW'(acc_nxt >> avg_q);
            acc          <= '0;
            rep          <= '0;
            idx          <= idx + AW'(1);
          end else begin
            acc <= acc_nxt;
            rep <= rep + 3'd1;
          end
          if (last_rep && last_in) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            st  <= S_ACQ;
            tmr <= acq_len - TW'(1);
          end
        end else begin
          tmr <= tmr - TW'(1);
        end
        S_ACQ: if (phase_end) begin
          st  <= S_CONV;
          tmr <= TW'(CONV_CYC - 1);
        end else begin
          tmr <= tmr - TW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_sweep_seq_chk.sv
module adc_sweep_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic conv_strobe,
  input logic acq_strobe
);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_first_conv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && conv_strobe));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(conv_strobe || acq_strobe));
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({conv_strobe, acq_strobe}) <= 1);
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !$past(done)) |=> (busy || done));
endmodule

bind adc_sweep_seq adc_sweep_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .conv_strobe(conv_strobe), .acq_strobe(acq_strobe)
);

// File: tb/adc_sweep_seq_bench.sv
module adc_sweep_seq_bench;
  localparam int SW = 12, CELLS = 6, AUXN = 6, NCH = 12, AW = 4, CW = 16;
  localparam int CONV = 3;
  localparam int ACQ[4] = '{2, 3, 5, 7};

  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] cfg_chan = 0, cfg_avg = 0, cfg_acq = 0;
  logic [SW-1:0] adc_data = 0;
  logic conv_strobe, acq_strobe, busy, done;
  logic [AW-1:0] chan_sel, rd_addr = 0;
  logic [CW-1:0] sweep_cycles;
  logic [SW-1:0] rd_data;

  int checks = 0, fails = 0, g = 0;
  int exp_sum[NCH];
  int exp_rf[NCH];

  always #10 clk = ~clk;

  adc_sweep_seq #(.SW(SW), .CELLS(CELLS), .AUXN(AUXN), .CONV_CYC(CONV),
    .ACQ_C0(2), .ACQ_C1(3), .ACQ_C2(5), .ACQ_C3(7), .CW(CW)) u_adc_sweep_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_chan(cfg_chan),
    .cfg_avg(cfg_avg), .cfg_acq(cfg_acq), .adc_data(adc_data),
    .conv_strobe(conv_strobe), .acq_strobe(acq_strobe), .chan_sel(chan_sel),
    .busy(busy), .done(done), .sweep_cycles(sweep_cycles),
    .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sweep(input int c, input int av, input int aq);
    int nin, nav, n, a, t, cyc, nconv, acqpos, guard;
    bit order_ok, gap_ok, first_ok;
    nin = (c == 0) ? NCH : (c == 1) ? CELLS + AUXN / 2 : CELLS;
    nav = 1 << av;
    n = nin * nav;
    a = ACQ[aq];
    t = n * CONV + (n - 1) * a;
    for (int i = 0; i < NCH; i++) exp_sum[i] = 0;
    @(negedge clk);
    cfg_chan = 2'(c); cfg_avg = 2'(av); cfg_acq = 2'(aq); start = 1;
    @(negedge clk);
    start = 0;
    cyc = 0; nconv = 0; acqpos = -100; guard = 0;
    order_ok = 1; gap_ok = 1; first_ok = 0;
    while (!done && guard < 5000) begin
      guard++;
      if (busy) cyc++;
      if (conv_strobe) begin
        int idx, ech;
        idx = nconv / nav;
        ech = (idx < CELLS) ? CELLS - 1 - idx : idx;
        if (int'(chan_sel) != ech) order_ok = 0;
        if (nconv == 0 && cyc == 1) first_ok = 1;
        if (nconv > 0 && cyc - acqpos != a) gap_ok = 0;
        adc_data = 12'((g * 173 + ech * 29 + 5) % 4096);
        if (ech < NCH) exp_sum[ech] += int'(adc_data);
        g++;
        nconv++;
      end
      if (acq_strobe) acqpos = cyc;
      if (cyc == 2) begin
        start = 1; cfg_chan = ~cfg_chan; cfg_avg = ~cfg_avg; cfg_acq = ~cfg_acq;
      end else if (cyc == 3) begin
        start = 0;
      end
      @(negedge clk);
    end
    start = 0;
    chk(done, "R7 done reached", int'(done), 1);
    chk(!busy, "R7 busy low at done", int'(busy), 0);
    chk(nconv == n, "R2 conversions per sweep", nconv, n);
    chk(order_ok, "R3 input order", int'(order_ok), 1);
    chk(gap_ok, "R5 acquisition window", int'(gap_ok), 1);
    chk(first_ok, "R9 first conversion strobe", int'(first_ok), 1);
    chk(cyc == t, "R6 R8 busy cycles", cyc, t);
    chk(int'(sweep_cycles) == t, "R6 sweep_cycles", int'(sweep_cycles), t);
    for (int i = 0; i < NCH; i++) begin
      bit swept;
      swept = (i < CELLS) || (i < nin);
      if (swept) exp_rf[i] = exp_sum[i] >> av;
    end
    @(negedge clk);
    chk(!done, "R7 done one cycle", int'(done), 0);
    for (int i = 0; i < NCH; i++) begin
      rd_addr = AW'(i);
      #1;
      chk(int'(rd_data) == exp_rf[i], "R4 R10 result", int'(rd_data), exp_rf[i]);
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) exp_rf[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done, "R1 idle after reset", int'({busy, done}), 0);
    chk(!conv_strobe && !acq_strobe, "R1 R9 strobes idle", int'({conv_strobe, acq_strobe}), 0);
    chk(sweep_cycles == 0, "R1 sweep_cycles", int'(sweep_cycles), 0);
    for (int i = 0; i < NCH; i++) begin
      rd_addr = AW'(i);
      #1;
      chk(rd_data == 0, "R1 result cleared", int'(rd_data), 0);
    end
    for (int c = 0; c < 4; c++)
      for (int av = 0; av < 4; av++)
        for (int aq = 0; aq < 4; aq++)
          sweep(c, av, aq);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule